// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive side of an Ethernet MAC and decides, for each incoming frame, whether the frame is kept or discarded. It watches the byte stream while the frame arrives and captures the six destination bytes. From those bytes it classes the frame as unicast, broadcast or multicast. At the end of the frame it applies a length rule, a basic address stage and an optional extended stage, and reports the outcome. The basic stage compares against one station address and a small set of multicast slots, and a promiscuous setting bypasses it. The extended stage compares against a second station address and a 32K-entry one-bit multicast bitmap.

Every filter setting is taken once, on the first byte of a frame, and held until that frame ends. The bitmap is loaded as 32-bit words through a simple write port. One cycle after the last byte, a one-cycle decision pulse carries accept, reject (frame too short) and a status byte with the class flags. Frame storage and data movement belong to the surrounding MAC.

Top module: `rx_addr_filter`

## Requirements
- R1: Byte i of the destination is the i-th byte of the frame. The frame is unicast when bit 0 of byte 0 is 0, broadcast when all six bytes are 0xFF, and multicast otherwise. On an accepted frame, status bit 6 (good) is set, bit 0 is set for multicast and bit 3 is set for broadcast. A unicast frame sets neither bit 0 nor bit 3.
- R2: A multicast frame whose bytes 0, 1, 2 are 0x01, 0x00, 0x52 is IP multicast, and an accepted one also sets status bit 1.
- R3: An address is given as a low word and a high half-word. Bytes 0..3 are compared with low-word bits 7:0, 15:8, 23:16, 31:24, and bytes 4..5 with high bits 7:0, 15:8. With promiscuous mode off, a unicast frame that differs from the station address in any byte is dropped.
- R4: With promiscuous mode on, the basic stage passes every frame.
- R5: With broadcast reject set, a broadcast frame is dropped in the basic stage, and also in the extended stage when that stage is on.
- R6: With promiscuous mode off, a multicast frame is dropped when multicast reject is set, or when it equals none of the four multicast slots.
- R7: The extended stage runs only when both extended enables are set. In that stage a unicast frame must equal the second station address, and an IP-multicast frame is dropped.
- R8: For a non-IP multicast frame in the extended stage, the index is ((byte4 & 0x7F) << 8) | byte5. Bitmap word index>>5, bit index&31 must be 1, or the frame is dropped. Word w is written with tbl_waddr = w.
- R9: With jumbo and VLAN sizes both disabled, a frame of 1519 to 1522 bytes is dropped, with no reject flag. 1518 and 1523 are unaffected by this rule.
- R10: A frame that passes every filter but is shorter than 12 bytes raises reject, with accept low and status 0. A short frame that fails a filter raises nothing.
- R11: dec_valid is a one-cycle pulse in the cycle after each last-byte beat. When dec_valid is low, accept, reject and status are all 0. Accept and reject are never both set.
- R12: The filter settings are sampled with the first byte. A change during the frame does not affect that frame's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame byte is present |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_len | input | LEN_W | Frame length in bytes, valid with in_eof |
| cfg_promisc | input | 1 | Bypass the basic stage |
| cfg_bcast_reject | input | 1 | Drop broadcast frames |
| cfg_mcast_reject | input | 1 | Drop multicast frames in the basic stage |
| cfg_ext_enable | input | 1 | Extended stage enable, first of two |
| cfg_ext_select | input | 1 | Extended stage enable, second of two |
| cfg_jumbo_en | input | 1 | Allow long frames |
| cfg_vlan_en | input | 1 | Allow tagged-size frames |
| cfg_uc_lo | input | 32 | Station address bytes 0..3 |
| cfg_uc_hi | input | 16 | Station address bytes 4..5 |
| cfg_xuc_lo | input | 32 | Extended station address bytes 0..3 |
| cfg_xuc_hi | input | 16 | Extended station address bytes 4..5 |
| cfg_mc_lo | input | MC_SLOTS*32 | Multicast slot low words, slot k at bits 32k+31:32k |
| cfg_mc_hi | input | MC_SLOTS*16 | Multicast slot high halves, slot k at bits 16k+15:16k |
| tbl_we | input | 1 | Bitmap word write strobe |
| tbl_waddr | input | HASH_IDX_W-5 | Bitmap word address |
| tbl_wdata | input | 32 | Bitmap word data |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_reject | output | 1 | Frame passed the filters but is too short |
| dec_status | output | STAT_W | Class flags of an accepted frame |

## Verification
The class decoder is swept over all 256 values of the first destination byte. This separates the unicast, multicast-slot and unmatched-multicast paths, and each byte position of the station address is then disturbed on its own to show the byte-to-word mapping. The bitmap is filled with a computed pattern and probed at several hundred spread indices, with the masked top bit of byte 4 toggled. This tells apart a correct word/bit split from a shifted or unmasked index. Lengths around the tagged-size window and below the minimum length separate a silent drop from a reject. A setting flipped partway through a frame shows whether the settings were held from the first byte.

// File: rtl/rx_af_pkg.sv
package rx_af_pkg;

   localparam int ST_MCAST = 0;
   localparam int ST_IPMC  = 1;
   localparam int ST_BCAST = 3;
   localparam int ST_GOOD  = 6;

   typedef enum logic [1:0] {
      CLS_UNI   = 2'd0,
      CLS_BCAST = 2'd1,
      CLS_MCAST = 2'd2
   } cls_e;

   // filter settings held for one frame; addresses store byte i at bits 8i+7:8i
   typedef struct packed {
      logic        promisc;
      logic        rej_bc;
      logic        rej_mc;
      logic        ext_a;
      logic        ext_b;
      logic        jumbo;
      logic        vlan;
      logic [47:0] uc;
      logic [47:0] xuc;
   } cfg_t;

   function automatic cls_e classify(input logic [47:0] d);
      if (!d[0])              return CLS_UNI;
      else if (&d)            return CLS_BCAST;
      else                    return CLS_MCAST;
   endfunction

endpackage

// File: rtl/rx_af_capture.sv
module rx_af_capture
   import rx_af_pkg::*;
#(
   parameter int MC_SLOTS = 4,
   localparam int MCW = MC_SLOTS * 48
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic           in_sof,
   input  logic [7:0]     in_data,
   input  cfg_t           cfg_live,
   input  logic [MCW-1:0] mc_live,
   output logic [47:0]    dst_now,
   output cfg_t           cfg_now,
   output logic [MCW-1:0] mc_now
);

   localparam int DST_BYTES = 6;

   logic [2:0]     cnt_q;
   logic [47:0]    dst_q;
   cfg_t           cfg_q;
   logic [MCW-1:0] mc_q;
   logic [2:0]     pos;
   logic           take;

   assign pos  = in_sof ? 3'd0 : cnt_q;
   assign take = in_valid && (int'(pos) < DST_BYTES);

   always_comb begin
      dst_now = in_sof ? 48'd0 : dst_q;
      if (take) dst_now[int'(pos)*8 +: 8] = in_data;
   end

   assign cfg_now = (in_valid && in_sof) ? cfg_live : cfg_q;
   assign mc_now  = (in_valid && in_sof) ? mc_live  : mc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dst_q <= '0;
         cfg_q <= '0;
         mc_q  <= '0;
      end else if (in_valid) begin
         dst_q <= dst_now;
         if (take) cnt_q <= pos + 3'd1;
         if (in_sof) begin
            cfg_q <= cfg_live;
            mc_q  <= mc_live;
         end
      end
   end

endmodule

// File: rtl/rx_af_hash_tbl.sv
module rx_af_hash_tbl #(
   parameter int IDX_W = 15,
   localparam int AW    = IDX_W - 5,
   localparam int WORDS = 1 << AW
)(
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [31:0]      wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit
);

   generate
      if (IDX_W < 6 || IDX_W > 16) begin : g_bad_idx
         $error("rx_af_hash_tbl: IDX_W must lie in 6..16");
      end
   endgenerate

   logic [31:0] mem [WORDS];
   logic [31:0] word;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // read is combinational so a six-byte frame still decides one cycle after its end
   assign word   = mem[rd_idx[IDX_W-1:5]];
   assign rd_bit = word[rd_idx[4:0]];

endmodule

// File: rtl/rx_af_decide.sv
module rx_af_decide
   import rx_af_pkg::*;
#(
   parameter int MC_SLOTS  = 4,
   parameter int LEN_W     = 16,
   parameter int STD_MAX   = 1518,
   parameter int TAG_BYTES = 4,
   parameter int MIN_LEN   = 12,
   parameter int STAT_W    = 8,
   localparam int MCW      = MC_SLOTS * 48
)(
   input  cfg_t              cfg,
   input  logic [MCW-1:0]    mc,
   input  logic [47:0]       dst,
   input  logic              hash_hit,
   input  logic [LEN_W-1:0]  len,
   output logic              accept,
   output logic              reject,
   output logic [STAT_W-1:0] status
);

   localparam int TAG_MAX = STD_MAX + TAG_BYTES;

   generate
      if (MC_SLOTS < 1) begin : g_bad_slots
         $error("rx_af_decide: MC_SLOTS must be at least 1");
      end
      if (TAG_MAX >= (1 << LEN_W)) begin : g_bad_len
         $error("rx_af_decide: LEN_W too narrow for the tagged-size window");
      end
      if (STAT_W <= ST_GOOD) begin : g_bad_stat
         $error("rx_af_decide: STAT_W too narrow for the status flags");
      end
   endgenerate

   cls_e                cls;
   logic                ipmc;
   logic [MC_SLOTS-1:0] slot_hit;
   logic                basic_ok, ext_ok, size_ok, pass, short_f;

   assign cls  = classify(dst);
   assign ipmc = (cls == CLS_MCAST) && (dst[23:0] == 24'h52_00_01);

   for (genvar g = 0; g < MC_SLOTS; g++) begin : g_slot
      assign slot_hit[g] = (dst == mc[g*48 +: 48]);
   end

   always_comb begin
      unique case (cls)
         CLS_UNI:   basic_ok = (dst == cfg.uc);
         CLS_BCAST: basic_ok = !cfg.rej_bc;
         default:   basic_ok = !cfg.rej_mc && (|slot_hit);
      endcase
      if (cfg.promisc) basic_ok = 1'b1;
   end

   always_comb begin
      unique case (cls)
         CLS_UNI:   ext_ok = (dst == cfg.xuc);
         CLS_BCAST: ext_ok = !cfg.rej_bc;
         default:   ext_ok = !ipmc && hash_hit;
      endcase
      if (!(cfg.ext_a && cfg.ext_b)) ext_ok = 1'b1;
   end

   assign size_ok = cfg.jumbo || cfg.vlan ||
                    !((int'(len) > STD_MAX) && (int'(len) <= TAG_MAX));
   assign pass    = size_ok && basic_ok && ext_ok;
   assign short_f = int'(len) < MIN_LEN;
   assign accept  = pass && !short_f;
   assign reject  = pass && short_f;

   always_comb begin
      status = '0;
      if (accept) begin
         status[ST_GOOD]  = 1'b1;
         status[ST_MCAST] = (cls == CLS_MCAST);
         status[ST_IPMC]  = ipmc;
         status[ST_BCAST] = (cls == CLS_BCAST);
      end
   end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rx_af_pkg::*;
#(
   parameter int MC_SLOTS   = 4,
   parameter int HASH_IDX_W = 15,
   parameter int LEN_W      = 16,
   parameter int STD_MAX    = 1518,
   parameter int TAG_BYTES  = 4,
   parameter int MIN_LEN    = 12,
   parameter int STAT_W     = 8,
   localparam int TBL_AW    = HASH_IDX_W - 5
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_sof,
   input  logic                   in_eof,
   input  logic [7:0]             in_data,
   input  logic [LEN_W-1:0]       in_len,
   input  logic                   cfg_promisc,
   input  logic                   cfg_bcast_reject,
   input  logic                   cfg_mcast_reject,
   input  logic                   cfg_ext_enable,
   input  logic                   cfg_ext_select,
   input  logic                   cfg_jumbo_en,
   input  logic                   cfg_vlan_en,
   input  logic [31:0]            cfg_uc_lo,
   input  logic [15:0]            cfg_uc_hi,
   input  logic [31:0]            cfg_xuc_lo,
   input  logic [15:0]            cfg_xuc_hi,
   input  logic [MC_SLOTS*32-1:0] cfg_mc_lo,
   input  logic [MC_SLOTS*16-1:0] cfg_mc_hi,
   input  logic                   tbl_we,
   input  logic [TBL_AW-1:0]      tbl_waddr,
   input  logic [31:0]            tbl_wdata,
   output logic                   dec_valid,
   output logic                   dec_accept,
   output logic                   dec_reject,
   output logic [STAT_W-1:0]      dec_status
);

   localparam int MCW = MC_SLOTS * 48;

   cfg_t                  cfg_live, cfg_now;
   logic [MCW-1:0]        mc_live, mc_now;
   logic [47:0]           dst_now;
   logic [15:0]           idx_raw;
   logic                  hash_hit;
   logic                  acc_c, rej_c;
   logic [STAT_W-1:0]     st_c;
   logic                  last_beat;

   always_comb begin
      cfg_live.promisc = cfg_promisc;
      cfg_live.rej_bc  = cfg_bcast_reject;
      cfg_live.rej_mc  = cfg_mcast_reject;
      cfg_live.ext_a   = cfg_ext_enable;
      cfg_live.ext_b   = cfg_ext_select;
      cfg_live.jumbo   = cfg_jumbo_en;
      cfg_live.vlan    = cfg_vlan_en;
      cfg_live.uc      = {cfg_uc_hi, cfg_uc_lo};
      cfg_live.xuc     = {cfg_xuc_hi, cfg_xuc_lo};
   end

   for (genvar k = 0; k < MC_SLOTS; k++) begin : g_mc_pack
      assign mc_live[k*48 +: 48] = {cfg_mc_hi[k*16 +: 16], cfg_mc_lo[k*32 +: 32]};
   end

   rx_af_capture #(.MC_SLOTS(MC_SLOTS)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sof   (in_sof),
      .in_data  (in_data),
      .cfg_live (cfg_live),
      .mc_live  (mc_live),
      .dst_now  (dst_now),
      .cfg_now  (cfg_now),
      .mc_now   (mc_now)
   );

   // byte 4 supplies the upper index bits, byte 5 the lower eight
   assign idx_raw = {dst_now[39:32], dst_now[47:40]};

   rx_af_hash_tbl #(.IDX_W(HASH_IDX_W)) u_tbl (
      .clk     (clk),
      .wr_en   (tbl_we),
      .wr_addr (tbl_waddr),
      .wr_data (tbl_wdata),
      .rd_idx  (idx_raw[HASH_IDX_W-1:0]),
      .rd_bit  (hash_hit)
   );

   rx_af_decide #(
      .MC_SLOTS (MC_SLOTS),
      .LEN_W    (LEN_W),
      .STD_MAX  (STD_MAX),
      .TAG_BYTES(TAG_BYTES),
      .MIN_LEN  (MIN_LEN),
      .STAT_W   (STAT_W)
   ) u_dec (
      .cfg      (cfg_now),
      .mc       (mc_now),
      .dst      (dst_now),
      .hash_hit (hash_hit),
      .len      (in_len),
      .accept   (acc_c),
      .reject   (rej_c),
      .status   (st_c)
   );

   assign last_beat = in_valid && in_eof;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_reject <= 1'b0;
         dec_status <= '0;
      end else begin
         dec_valid  <= last_beat;
         dec_accept <= last_beat && acc_c;
         dec_reject <= last_beat && rej_c;
         dec_status <= last_beat ? st_c : '0;
      end
   end

endmodule

// File: rtl/rx_af_chk.sv
module rx_af_chk #(
   parameter int STAT_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_eof,
   input logic              dec_valid,
   input logic              dec_accept,
   input logic              dec_reject,
   input logic [STAT_W-1:0] dec_status
);

   p_valid_after_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |=> dec_valid);

   p_no_stray_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_eof) |=> !dec_valid);

   p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!dec_accept && !dec_reject && dec_status == '0));

   p_accept_excl_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_accept && dec_reject));

   p_status_only_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_accept |-> (dec_status == '0));

   p_good_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dec_accept |-> dec_status[6]);

   p_one_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dec_status[0], dec_status[3]}));

   p_ipmc_is_mcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_status[1] |-> dec_status[0]);

endmodule

bind rx_addr_filter rx_af_chk #(.STAT_W(STAT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_eof     (in_eof),
   .dec_valid  (dec_valid),
   .dec_accept (dec_accept),
   .dec_reject (dec_reject),
   .dec_status (dec_status)
);

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;

   localparam int SLOTS = 4;
   localparam int WORDS = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              in_valid = 0, in_sof = 0, in_eof = 0;
   logic [7:0]        in_data = 0;
   logic [15:0]       in_len = 0;
   logic              cfg_promisc = 0, cfg_bcast_reject = 0, cfg_mcast_reject = 0;
   logic              cfg_ext_enable = 0, cfg_ext_select = 0, cfg_jumbo_en = 1, cfg_vlan_en = 0;
   logic [31:0]       cfg_uc_lo, cfg_xuc_lo;
   logic [15:0]       cfg_uc_hi, cfg_xuc_hi;
   logic [SLOTS*32-1:0] cfg_mc_lo;
   logic [SLOTS*16-1:0] cfg_mc_hi;
   logic              tbl_we = 0;
   logic [9:0]        tbl_waddr = 0;
   logic [31:0]       tbl_wdata = 0;
   logic              dec_valid, dec_accept, dec_reject;
   logic [7:0]        dec_status;

   rx_addr_filter dut (.*);

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] mirror [WORDS];

   function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
      return {b5, b4, b3, b2, b1, b0};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected {valid, accept, reject, status} from the requirement text
   function automatic logic [10:0] model(input logic [47:0] d_in, input int len);
      logic [47:0] d;
      logic uni, bc, mc, ip, pass, hit;
      int idx;
      d = d_in;
      for (int i = 0; i < 6; i++) if (i >= len) d[8*i +: 8] = 8'h00;
      uni = !d[0];
      bc  = (d == 48'hFFFF_FFFF_FFFF);
      mc  = !uni && !bc;
      ip  = mc && d[7:0] == 8'h01 && d[15:8] == 8'h00 && d[23:16] == 8'h52;
      pass = 1;
      if (!cfg_jumbo_en && !cfg_vlan_en && len >= 1519 && len <= 1522) pass = 0;
      if (!cfg_promisc) begin
         if (uni) pass &= (d == {cfg_uc_hi, cfg_uc_lo});
         else if (bc) pass &= !cfg_bcast_reject;
         else begin
            hit = 0;
            for (int s = 0; s < SLOTS; s++)
               if (d == {cfg_mc_hi[16*s +: 16], cfg_mc_lo[32*s +: 32]}) hit = 1;
            pass &= !cfg_mcast_reject && hit;
         end
      end
      if (cfg_ext_enable && cfg_ext_select) begin
         if (uni) pass &= (d == {cfg_xuc_hi, cfg_xuc_lo});
         else if (bc) pass &= !cfg_bcast_reject;
         else begin
            idx = ((int'(d[39:32]) & 8'h7F) << 8) | int'(d[47:40]);
            pass &= !ip && mirror[idx >> 5][idx & 31];
         end
      end
      if (!pass)          return {1'b1, 1'b0, 1'b0, 8'h00};
      else if (len < 12)  return {1'b1, 1'b0, 1'b1, 8'h00};
      else return {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, bc, 1'b0, ip, mc};
   endfunction

   task automatic send(input logic [47:0] d, input int len, input int flip_at);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1;
         in_sof   = (i == 0);
         in_eof   = (i == len - 1);
         in_data  = (i < 6) ? d[8*i +: 8] : 8'(i);
         in_len   = 16'(len);
         if (i == flip_at) cfg_promisc = ~cfg_promisc;
      end
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0;
   endtask

   task automatic run(input string req, input logic [47:0] d, input int len);
      logic [10:0] e;
      e = model(d, len);
      send(d, len, -1);
      chk(req, {21'd0, dec_valid, dec_accept, dec_reject, dec_status}, {21'd0, e});
   endtask

   task automatic twrite(input int w, input logic [31:0] v);
      @(negedge clk);
      tbl_we = 1; tbl_waddr = 10'(w); tbl_wdata = v;
      mirror[w] = v;
      @(negedge clk);
      tbl_we = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [10:0] e;
      cfg_uc_lo  = 32'h3322_1100; cfg_uc_hi  = 16'h5544;
      cfg_xuc_lo = 32'hCCBB_AA00; cfg_xuc_hi = 16'hEEDD;
      cfg_mc_lo  = {32'h3322_1105, 32'h0000_3333, 32'h00C2_8001, 32'h0152_0001};
      cfg_mc_hi  = {16'h5544, 16'h0100, 16'h0100, 16'h0302};
      for (int w = 0; w < WORDS; w++) mirror[w] = 32'h0;

      repeat (3) @(negedge clk);
      chk("R11 reset valid", {31'd0, dec_valid}, 0);
      chk("R11 reset accept", {31'd0, dec_accept}, 0);
      rst_n = 1;
      for (int w = 0; w < WORDS; w++) twrite(w, (32'(w) * 32'h9E37_79B1) ^ (32'(w) << 7));

      // R1: sweep the first destination byte
      for (int b = 0; b < 256; b++) run("R1 class sweep", mk(8'(b), 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 14);
      run("R1 broadcast accept", 48'hFFFF_FFFF_FFFF, 64);
      chk("R1 broadcast status", {24'd0, dec_status}, 32'h48);
      run("R1 unicast accept", mk(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 64);
      chk("R1 unicast status", {24'd0, dec_status}, 32'h40);

      // R11: one-cycle pulse
      @(negedge clk);
      chk("R11 pulse width", {31'd0, dec_valid}, 0);

      // R3: disturb each byte alone
      for (int p = 0; p < 6; p++) begin
         logic [47:0] d;
         d = mk(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
         d[8*p + 1] = ~d[8*p + 1];
         run("R3 byte mismatch", d, 40);
         chk("R3 mismatch dropped", {31'd0, dec_accept}, 0);
      end

      // R2: IP multicast through slot 0
      run("R2 ip multicast", mk(8'h01, 8'h00, 8'h52, 8'h01, 8'h02, 8'h03), 40);
      chk("R2 status", {24'd0, dec_status}, 32'h43);

      // R6: slots and reject
      run("R6 slot1", mk(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01), 40);
      run("R6 slot2", mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 40);
      run("R6 slot3", mk(8'h05, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 40);
      run("R6 no slot", mk(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h02), 40);
      cfg_mcast_reject = 1;
      run("R6 mcast reject", mk(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01), 40);
      chk("R6 rejected slot frame", {31'd0, dec_accept}, 0);
      cfg_mcast_reject = 0;

      // R5
      cfg_bcast_reject = 1;
      run("R5 bcast reject", 48'hFFFF_FFFF_FFFF, 40);
      chk("R5 dropped", {31'd0, dec_accept}, 0);
      cfg_promisc = 1; cfg_ext_enable = 1; cfg_ext_select = 1;
      run("R5 bcast reject ext stage", 48'hFFFF_FFFF_FFFF, 40);
      cfg_promisc = 0; cfg_ext_enable = 0; cfg_ext_select = 0; cfg_bcast_reject = 0;

      // R4
      cfg_promisc = 1;
      run("R4 promisc unicast", mk(8'h02, 8'h99, 8'h98, 8'h97, 8'h96, 8'h95), 40);
      chk("R4 accepted", {31'd0, dec_accept}, 1);
      run("R4 promisc mcast", mk(8'h07, 8'h99, 8'h98, 8'h97, 8'h96, 8'h95), 40);

      // R7: one enable alone has no effect
      cfg_ext_enable = 1;
      run("R7 single enable", mk(8'h02, 8'h99, 8'h98, 8'h97, 8'h96, 8'h95), 40);
      chk("R7 single enable accepted", {31'd0, dec_accept}, 1);
      cfg_ext_enable = 0; cfg_ext_select = 1;
      run("R7 other enable alone", mk(8'h02, 8'h99, 8'h98, 8'h97, 8'h96, 8'h95), 40);
      cfg_ext_enable = 1;
      run("R7 ext unicast match", mk(8'h00, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE), 40);
      chk("R7 ext unicast accepted", {31'd0, dec_accept}, 1);
      run("R7 station address in ext", mk(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 40);
      chk("R7 station address dropped", {31'd0, dec_accept}, 0);
      run("R7 ip multicast dropped", mk(8'h01, 8'h00, 8'h52, 8'h7F, 8'hFF, 8'hFF), 40);

      // R8: bitmap probes
      for (int k = 0; k < 512; k++) begin
         int idx;
         idx = (k * 61 + 7) % 32768;
         run("R8 bitmap probe", mk(8'h03, 8'h00, 8'h00, 8'h00,
                                   8'((idx >> 8) | ((k & 1) << 7)), 8'(idx & 255)), 14);
      end
      twrite(77, 32'h0000_0000);
      run("R8 cleared word", mk(8'h03, 8'h00, 8'h00, 8'h00, 8'h09, 8'hA4), 14);
      chk("R8 cleared word dropped", {31'd0, dec_accept}, 0);
      twrite(77, 32'h0000_0010);
      run("R8 set bit", mk(8'h03, 8'h00, 8'h00, 8'h00, 8'h89, 8'hA4), 14);
      chk("R8 set bit accepted", {31'd0, dec_accept}, 1);
      cfg_promisc = 0; cfg_ext_enable = 0; cfg_ext_select = 0;

      // R9: length window over jumbo/vlan settings
      for (int c = 0; c < 4; c++) begin
         cfg_jumbo_en = c[0]; cfg_vlan_en = c[1];
         run("R9 len 1518", mk(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1518);
         run("R9 len 1519", mk(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1519);
         run("R9 len 1522", mk(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1522);
         run("R9 len 1523", mk(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1523);
      end
      cfg_jumbo_en = 1; cfg_vlan_en = 0;

      // R10: short frames
      for (int l = 1; l <= 13; l++) run("R10 short length", mk(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), l);
      cfg_promisc = 1;
      for (int l = 1; l <= 13; l++) run("R10 short promisc", mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), l);
      cfg_promisc = 0;
      run("R10 short failing filter", mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 8);
      chk("R10 no reject on drop", {31'd0, dec_reject}, 0);

      // R12: settings flipped mid-frame
      e = model(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 30);
      send(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 30, 3);
      chk("R12 promisc set mid-frame", {21'd0, dec_valid, dec_accept, dec_reject, dec_status}, {21'd0, e});
      e = model(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 30);
      send(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 30, 4);
      chk("R12 promisc cleared mid-frame", {21'd0, dec_valid, dec_accept, dec_reject, dec_status}, {21'd0, e});
      chk("R12 accepted", {31'd0, dec_accept}, 1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule